// File: doc/BRIEF.md
# Host Command Mailbox

The block sits between a 32-bit host register port and a device command processor. Host software fills a sixteen-word command window with a 64-byte command. It then sets an execute bit in a control register and polls that bit. When the bit reads back as zero, software collects sixteen response words from a separate response window. Each command is always a full 64 bytes, and software pads unused words with zeros. Word 0 carries a 16-bit opcode in its upper half. The opcode low nibble picks create, modify, query or destroy, and the object class advances in steps of 0x10 from 0x0200. The mailbox does not interpret any of this. It only moves the words.

On the device side, the whole command goes out as one 512-bit word under a valid/ready handshake. The 512-bit response comes back under a second valid/ready handshake. The execute bit doubles as the busy flag. It is set by the host write and cleared by the device response. The same register space also serves three read-only identification words: the port count, the offset of the per-port registers and their stride.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, cmdValid and rspReady are 0, the control register reads 0, and every command and response word reads 0.
- R2: Byte offsets 0x100, 0x104 and 0x108 read PORT_COUNT, PORT_OFFSET and PORT_STRIDE. Host writes to them have no effect.
- R3: A host write at 0x10000 + 4k (k = 0..15) stores word k of the command while idle. Reading that address returns the word. On cmdData, word k occupies bits [32k+31:32k]. Read data appears on hostRdData in the cycle after hostRdEn.
- R4: While idle, writing a value with bit 0 set to offset 0x200 raises cmdValid in the next cycle. cmdValid and cmdData then hold steady until cmdReady is seen high.
- R5: Bit 0 of offset 0x200 reads 1 from the start of a command until its response is taken. Writing 0, or writing 1 again while busy, changes nothing.
- R6: rspReady rises only in the cycle after the command handshake. It is never high together with cmdValid. A response handshake latches rspData into the response window and clears busy at the same clock edge.
- R7: Host writes to the command window while busy are ignored.
- R8: The response window at 0x10040 + 4k changes only on a response handshake. Host writes to it, and rspValid raised before the command is accepted, leave it unchanged.
- R9: Reads of unmapped or misaligned offsets (bits [1:0] not zero) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe |
| hostAddr | input | 17 | Host byte offset |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, one cycle after hostRdEn |
| cmdValid | output | 1 | Command offered to the device |
| cmdReady | input | 1 | Device accepts the command |
| cmdData | output | 512 | Sixteen command words, word 0 lowest |
| rspValid | input | 1 | Device offers a response |
| rspReady | output | 1 | Mailbox waits for a response |
| rspData | input | 512 | Sixteen response words, word 0 lowest |

## Verification
The hardest case to reach is a device that raises rspValid early, while the command is still waiting for cmdReady. The mailbox must not take that response. It must take it only in the cycle after the command handshake. The bench holds cmdReady low for several cycles with rspValid already high and a new response pattern on rspData. It confirms that the old response stays readable. It then releases cmdReady and checks that the new response arrives exactly one cycle later. Writes to the command window, the response window and the control bit are also issued during the busy period, to show that none of them takes effect.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W    = 17;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 16;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int BLOCK_W   = WORD_W * NUM_WORDS;
  localparam int WIN_LSB   = IDX_W + 2;

  localparam logic [ADDR_W-1:0] CMD_BASE    = 17'h10000;
  localparam logic [ADDR_W-1:0] RSP_BASE    = 17'h10040;
  localparam logic [ADDR_W-1:0] CTRL_ADDR   = 17'h00200;
  localparam logic [ADDR_W-1:0] COUNT_ADDR  = 17'h00100;
  localparam logic [ADDR_W-1:0] OFFSET_ADDR = 17'h00104;
  localparam logic [ADDR_W-1:0] STRIDE_ADDR = 17'h00108;

  typedef enum logic [2:0] {
    REG_NONE, REG_COUNT, REG_OFFSET, REG_STRIDE, REG_CTRL, REG_CMD, REG_RSP
  } regSel_t;

  typedef struct packed {
    logic             cmdWr;
    logic [IDX_W-1:0] wordIdx;
    logic             rspLoad;
  } mboxStrobe_t;

  function automatic regSel_t decodeAddr(input logic [ADDR_W-1:0] a);
    regSel_t sel;
    sel = REG_NONE;
    if (a[1:0] == 2'b00) begin
      if (a[ADDR_W-1:WIN_LSB] == CMD_BASE[ADDR_W-1:WIN_LSB])      sel = REG_CMD;
      else if (a[ADDR_W-1:WIN_LSB] == RSP_BASE[ADDR_W-1:WIN_LSB]) sel = REG_RSP;
      else if (a == CTRL_ADDR)   sel = REG_CTRL;
      else if (a == COUNT_ADDR)  sel = REG_COUNT;
      else if (a == OFFSET_ADDR) sel = REG_OFFSET;
      else if (a == STRIDE_ADDR) sel = REG_STRIDE;
    end
    return sel;
  endfunction
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  input  logic              cmdReady,
  input  logic              rspValid,
  output logic              busy,
  output logic              cmdValid,
  output logic              rspReady,
  output mboxStrobe_t       strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} state_t;

  state_t  state;
  regSel_t wrSel;
  logic    startReq;

  always_comb begin
    wrSel          = decodeAddr(hostAddr);
    startReq       = hostWrEn && (wrSel == REG_CTRL) && hostWrData[0] && (state == ST_IDLE);
    strobe.cmdWr   = hostWrEn && (wrSel == REG_CMD) && (state == ST_IDLE);
    strobe.wordIdx = hostAddr[WIN_LSB-1:2];
    strobe.rspLoad = (state == ST_WAIT) && rspValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (startReq) state <= ST_SEND;
        ST_SEND: if (cmdReady) state <= ST_WAIT;
        ST_WAIT: if (rspValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign cmdValid = (state == ST_SEND);
  assign rspReady = (state == ST_WAIT);
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter logic [WORD_W-1:0] PORT_COUNT  = 32'd1,
  parameter logic [WORD_W-1:0] PORT_OFFSET = 32'h1000,
  parameter logic [WORD_W-1:0] PORT_STRIDE = 32'h1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  mboxStrobe_t        strobe,
  input  logic               hostRdEn,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [WORD_W-1:0]  hostWrData,
  input  logic               busy,
  input  logic [BLOCK_W-1:0] rspData,
  output logic [BLOCK_W-1:0] cmdData,
  output logic [WORD_W-1:0]  hostRdData
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] cmdMem;
  logic [NUM_WORDS-1:0][WORD_W-1:0] rspMem;
  logic [IDX_W-1:0]                 rdIdx;

  assign rdIdx   = hostAddr[WIN_LSB-1:2];
  assign cmdData = cmdMem;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmdMem[w] <= '0;
        rspMem[w] <= '0;
      end else begin
        if (strobe.cmdWr && (strobe.wordIdx == IDX_W'(w))) cmdMem[w] <= hostWrData;
        if (strobe.rspLoad) rspMem[w] <= rspData[w*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdData <= '0;
    end else if (hostRdEn) begin
      case (decodeAddr(hostAddr))
        REG_COUNT:  hostRdData <= PORT_COUNT;
        REG_OFFSET: hostRdData <= PORT_OFFSET;
        REG_STRIDE: hostRdData <= PORT_STRIDE;
        REG_CTRL:   hostRdData <= {{(WORD_W-1){1'b0}}, busy};
        REG_CMD:    hostRdData <= cmdMem[rdIdx];
        REG_RSP:    hostRdData <= rspMem[rdIdx];
        default:    hostRdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbox_pkg::*;
#(
  parameter logic [WORD_W-1:0] PORT_COUNT  = 32'd1,
  parameter logic [WORD_W-1:0] PORT_OFFSET = 32'h1000,
  parameter logic [WORD_W-1:0] PORT_STRIDE = 32'h1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [WORD_W-1:0]  hostWrData,
  output logic [WORD_W-1:0]  hostRdData,
  output logic               cmdValid,
  input  logic               cmdReady,
  output logic [BLOCK_W-1:0] cmdData,
  input  logic               rspValid,
  output logic               rspReady,
  input  logic [BLOCK_W-1:0] rspData
);
  mboxStrobe_t strobe;
  logic        busy;

  mbox_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .cmdReady(cmdReady), .rspValid(rspValid),
    .busy(busy), .cmdValid(cmdValid), .rspReady(rspReady), .strobe(strobe)
  );

  mbox_datapath #(
    .PORT_COUNT(PORT_COUNT), .PORT_OFFSET(PORT_OFFSET), .PORT_STRIDE(PORT_STRIDE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .busy(busy),
    .rspData(rspData), .cmdData(cmdData), .hostRdData(hostRdData)
  );
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk
  import mbox_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic               cmdReady,
  input logic [BLOCK_W-1:0] cmdData,
  input logic               rspValid,
  input logic               rspReady
);
  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdData)));

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && rspReady));

  assert_rsp_after_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspReady) |-> $past(cmdValid && cmdReady));

  assert_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady) |=> (!rspReady && !cmdValid));

  assert_cmd_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdValid || rspReady) && !(rspValid && rspReady)) |=> $stable(cmdData));
endmodule

bind cmd_mailbox cmd_mailbox_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdData(cmdData), .rspValid(rspValid), .rspReady(rspReady)
);

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;
  localparam logic [31:0] P_COUNT  = 32'd4;
  localparam logic [31:0] P_OFFSET = 32'h0000_8000;
  localparam logic [31:0] P_STRIDE = 32'h0000_0400;
  localparam logic [16:0] A_CTRL = 17'h00200;
  localparam logic [16:0] A_CMD  = 17'h10000;
  localparam logic [16:0] A_RSP  = 17'h10040;

  typedef struct packed {
    logic [16:0] addr;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{17'h00100, P_COUNT}, '{17'h00104, P_OFFSET}, '{17'h00108, P_STRIDE},
    '{17'h00102, 32'h0}, '{17'h00300, 32'h0}, '{17'h10080, 32'h0},
    '{17'h00000, 32'h0}, '{17'h10041, 32'h0}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [16:0]  hostAddr = '0;
  logic [31:0]  hostWrData = '0;
  logic [31:0]  hostRdData;
  logic         cmdValid, rspReady;
  logic         cmdReady = 1'b0, rspValid = 1'b0;
  logic [511:0] cmdData, rspData = '0;

  int numChecks = 0;
  int numFail = 0;
  bit done = 1'b0;

  logic [31:0]  cmdWords [16];
  logic [511:0] expCmd, rsp1, rsp2;
  logic [31:0]  rd;

  always #2 clk = ~clk;

  cmd_mailbox #(.PORT_COUNT(P_COUNT), .PORT_OFFSET(P_OFFSET), .PORT_STRIDE(P_STRIDE)) u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData)
  );

  task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [16:0] a, input logic [31:0] d);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [16:0] a, output logic [31:0] d);
    hostRdEn = 1'b1; hostAddr = a;
    @(negedge clk);
    hostRdEn = 1'b0;
    d = hostRdData;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      numChecks++;
      numFail++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) cmdWords[k] = 32'h1111_0000 * (k + 1) + 32'(k);
    cmdWords[0] = 32'h0210_0000;
    for (int k = 0; k < 16; k++) begin
      expCmd[k*32 +: 32] = cmdWords[k];
      rsp1[k*32 +: 32]   = 32'hA5A5_0000 + 32'(k);
      rsp2[k*32 +: 32]   = 32'h5A00_0000 + 32'(k * 3);
    end

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cmdValid", {511'b0, cmdValid}, 512'b0);
    check("R1 rspReady", {511'b0, rspReady}, 512'b0);
    rstN = 1'b1;
    @(negedge clk);
    hostRead(A_CTRL, rd);     check("R1 ctrl", {480'b0, rd}, 512'b0);
    hostRead(A_CMD + 17'd8, rd); check("R1 cmd word", {480'b0, rd}, 512'b0);
    hostRead(A_RSP + 17'd60, rd); check("R1 rsp word", {480'b0, rd}, 512'b0);

    // R2 / R9 table walk
    foreach (VECS[i]) begin
      hostRead(VECS[i].addr, rd);
      check((i < 3) ? "R2 id reg" : "R9 unmapped", {480'b0, rd}, {480'b0, VECS[i].exp});
    end
    hostWrite(17'h00104, 32'hDEAD_BEEF);
    hostRead(17'h00104, rd); check("R2 write ignored", {480'b0, rd}, {480'b0, P_OFFSET});

    // R3 command window fill and readback
    for (int k = 0; k < 16; k++) hostWrite(A_CMD + 17'(4 * k), cmdWords[k]);
    hostRead(A_CMD, rd);          check("R3 word0 opcode", {496'b0, rd[31:16]}, {496'b0, 16'h0210});
    hostRead(A_CMD + 17'd44, rd); check("R3 word11", {480'b0, rd}, {480'b0, cmdWords[11]});
    check("R3 cmdData layout", cmdData, expCmd);

    // R5 writing 0 does not start
    hostWrite(A_CTRL, 32'h0);
    check("R5 zero write no start", {511'b0, cmdValid}, 512'b0);

    // R4 start and hold
    hostWrite(A_CTRL, 32'h1);
    check("R4 cmdValid raised", {511'b0, cmdValid}, {511'b0, 1'b1});
    hostWrite(A_CMD + 17'd12, 32'hBAD0_0003);   // R7 ignored
    hostWrite(A_RSP, 32'hBAD0_0000);            // R8 ignored
    hostWrite(A_CTRL, 32'h1);                   // R5 ignored
    hostRead(A_CTRL, rd); check("R5 busy reads 1", {480'b0, rd}, 512'b1);
    check("R4 still valid", {511'b0, cmdValid}, {511'b0, 1'b1});
    check("R7 cmdData frozen", cmdData, expCmd);
    check("R6 no rspReady while sending", {511'b0, rspReady}, 512'b0);
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
    check("R4 valid dropped after accept", {511'b0, cmdValid}, 512'b0);
    check("R6 rspReady after accept", {511'b0, rspReady}, {511'b0, 1'b1});
    hostRead(A_RSP, rd); check("R8 rsp before handshake", {480'b0, rd}, 512'b0);
    hostRead(A_CMD + 17'd12, rd); check("R7 cmd write ignored", {480'b0, rd}, {480'b0, cmdWords[3]});
    rspData = rsp1; rspValid = 1'b1;
    @(negedge clk);
    rspValid = 1'b0;
    check("R6 rspReady dropped", {511'b0, rspReady}, 512'b0);
    hostRead(A_CTRL, rd); check("R6 busy cleared", {480'b0, rd}, 512'b0);
    for (int k = 0; k < 16; k += 5) begin
      hostRead(A_RSP + 17'(4 * k), rd);
      check("R6 rsp latched", {480'b0, rd}, {480'b0, rsp1[k*32 +: 32]});
    end

    // R8 early rspValid during send is not taken
    hostWrite(A_CTRL, 32'h3);
    rspData = rsp2; rspValid = 1'b1;
    repeat (3) @(negedge clk);
    hostRead(A_RSP + 17'd4, rd); check("R8 early rsp ignored", {480'b0, rd}, {480'b0, rsp1[63:32]});
    check("R6 exclusive", {511'b0, rspReady}, 512'b0);
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
    check("R6 rspReady one cycle after", {511'b0, rspReady}, {511'b0, 1'b1});
    @(negedge clk);
    rspValid = 1'b0;
    check("R6 immediate completion", {511'b0, rspReady}, 512'b0);
    hostRead(A_RSP + 17'd4, rd);  check("R8 second rsp", {480'b0, rd}, {480'b0, rsp2[63:32]});
    hostRead(A_RSP + 17'd60, rd); check("R8 second rsp last", {480'b0, rd}, {480'b0, rsp2[511:480]});

    // R3 writable again after completion
    hostWrite(A_CMD + 17'd12, 32'h0000_7777);
    hostRead(A_CMD + 17'd12, rd); check("R3 write after done", {480'b0, rd}, 512'h7777);

    done = 1'b1;
    finishRun();
  end
endmodule